// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between an on-chip valid/ready request bus and an external asynchronous static RAM of 128K bytes. Each accepted request is a single read or a single write. The block turns it into a timed sequence on the RAM's pins: a 17-bit address, an active-low select together with an active-high select, an active-low write strobe and an active-low output strobe. The 8-bit data bus is bidirectional. The block exposes it as three signals: a drive value, a drive enable and a sampled input.

The device timing comes in as nanosecond parameters together with a clock-period parameter. Package functions round each value up to whole clock cycles. Each phase takes the largest of the cycle counts that constrain it. A write first opens a turnaround window: the write strobe is low but the data bus is not yet driven, so the RAM's output drivers have time to float. The data is then driven for the setup window. The write strobe is released first, and address and data are held for one further cycle. A read holds the output strobe low for the access count and registers the data bus on the last cycle of that count. It then returns one response pulse.

Only one request is in flight at a time. The ready signal is high only while the sequencer is idle.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While idle and during reset, the RAM is deselected (sram_cs1_n=1, sram_cs2=0), sram_we_n=1, sram_oe_n=1, sram_dq_oe=0, rsp_valid=0, and req_ready=1 outside reset.
- R2: After a request is accepted, req_ready stays low for TURN+DRIVE+1 cycles for a write and RD cycles for a read, and then returns high.
- R3: During a write, sram_we_n is low for exactly TURN+DRIVE consecutive cycles, and only while the RAM is selected (sram_cs1_n=0, sram_cs2=1), with sram_oe_n=1 and sram_addr equal to the request address.
- R4: For the first TURN cycles of sram_we_n low, sram_dq_oe is 0 (bus turnaround).
- R5: For the remaining DRIVE cycles of sram_we_n low, sram_dq_oe=1 and sram_dq_out carries the request data. In the cycle after sram_we_n rises, sram_dq_oe is still 1 and sram_addr is unchanged.
- R6: During a read, the RAM is selected, sram_oe_n is low for exactly RD consecutive cycles, sram_we_n=1, and sram_dq_oe=0.
- R7: rsp_valid is a one-cycle pulse in the first cycle after sram_oe_n rises at the end of a read. Each read gives exactly one pulse.
- R8: rsp_rdata equals sram_dq_in as sampled on the last cycle of the read access. A read therefore returns the byte most recently written to that address.
- R9: sram_we_n and sram_oe_n are never low in the same cycle.

With period P, TURN = max(1, ceil(we_to_hiz/P), ceil(oe_to_hiz/P)). DRIVE = max(1, ceil(setup/P), ceil(pulse/P)-TURN, ceil(write_cycle/P)-TURN-1). RD = max(1, ceil(addr_access/P), ceil(oe_access/P), ceil(read_cycle/P)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 8 | Read data |
| sram_addr | output | 17 | RAM address bus |
| sram_cs1_n | output | 1 | Active-low RAM select |
| sram_cs2 | output | 1 | Active-high RAM select |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output strobe |
| sram_dq_out | output | 8 | Data bus drive value |
| sram_dq_oe | output | 1 | Data bus drive enable |
| sram_dq_in | input | 8 | Data bus sampled value |

## Verification
The bench builds the block with a 10 ns period and raises four of the nanosecond parameters. The write-strobe float time is 15 ns, data setup is 25 ns, the write pulse is 35 ns and address access is 45 ns. This gives a turnaround of two cycles, three drive cycles and a five-cycle read. Each window is therefore longer than one cycle, so an off-by-one in any counter, or a swapped maximum in the rounding arithmetic, changes a visible strobe width. The RAM model in the bench returns a wrong value before the second read cycle, and it commits writes only on the rising edge of the write strobe. An early data capture, or a write strobe that is released too late or too soon, therefore shows up as wrong read data.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE      = 3'd0,
    PH_WR_TURN   = 3'd1,
    PH_WR_DRIVE  = 3'd2,
    PH_WR_HOLD   = 3'd3,
    PH_RD_ACCESS = 3'd4
  } phase_t;

  typedef struct packed {
    logic cs1_n;
    logic cs2;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } strobe_t;

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per_ns);
    return (ns + per_ns - 1) / per_ns;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned usub0(input int unsigned a, input int unsigned b);
    return (a > b) ? (a - b) : 0;
  endfunction

  // cycles with the write strobe low before the data bus may be driven
  function automatic int unsigned wr_turn_cycles(input int unsigned per_ns,
                                                 input int unsigned we_hiz_ns,
                                                 input int unsigned oe_hiz_ns);
    return umax(1, umax(ns_to_cyc(we_hiz_ns, per_ns), ns_to_cyc(oe_hiz_ns, per_ns)));
  endfunction

  // cycles with data driven and the write strobe still low
  function automatic int unsigned wr_drive_cycles(input int unsigned per_ns,
                                                  input int unsigned setup_ns,
                                                  input int unsigned pulse_ns,
                                                  input int unsigned wcycle_ns,
                                                  input int unsigned turn_cyc);
    int unsigned s, p, c;
    s = ns_to_cyc(setup_ns, per_ns);
    p = usub0(ns_to_cyc(pulse_ns, per_ns), turn_cyc);
    c = usub0(ns_to_cyc(wcycle_ns, per_ns), turn_cyc + 1);
    return umax(1, umax(s, umax(p, c)));
  endfunction

  // cycles with the output strobe low during a read
  function automatic int unsigned rd_access_cycles(input int unsigned per_ns,
                                                   input int unsigned addr_acc_ns,
                                                   input int unsigned oe_acc_ns,
                                                   input int unsigned rcycle_ns);
    return umax(1, umax(ns_to_cyc(addr_acc_ns, per_ns),
                        umax(ns_to_cyc(oe_acc_ns, per_ns), ns_to_cyc(rcycle_ns, per_ns))));
  endfunction

  function automatic strobe_t phase_strobes(input phase_t ph);
    strobe_t s;
    s = '{cs1_n: 1'b1, cs2: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
    case (ph)
      PH_WR_TURN:   s = '{cs1_n: 1'b0, cs2: 1'b1, we_n: 1'b0, oe_n: 1'b1, dq_oe: 1'b0};
      PH_WR_DRIVE:  s = '{cs1_n: 1'b0, cs2: 1'b1, we_n: 1'b0, oe_n: 1'b1, dq_oe: 1'b1};
      PH_WR_HOLD:   s = '{cs1_n: 1'b0, cs2: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b1};
      PH_RD_ACCESS: s = '{cs1_n: 1'b0, cs2: 1'b1, we_n: 1'b1, oe_n: 1'b0, dq_oe: 1'b0};
      default:      s = '{cs1_n: 1'b1, cs2: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned TURN_CYC  = 1,
  parameter int unsigned DRIVE_CYC = 2,
  parameter int unsigned RD_CYC    = 3,
  parameter int unsigned CNT_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             is_write,
  input  logic             expire,
  output phase_t           phase,
  output phase_t           phase_nxt,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             capture
);
  localparam logic [CNT_W-1:0] TURN_LD  = CNT_W'(TURN_CYC - 1);
  localparam logic [CNT_W-1:0] DRIVE_LD = CNT_W'(DRIVE_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LD    = CNT_W'(RD_CYC - 1);

  phase_t phase_q;

  always_comb begin
    phase_nxt = phase_q;
    load      = 1'b0;
    load_val  = '0;
    capture   = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (accept) begin
          load = 1'b1;
          if (is_write) begin
            phase_nxt = PH_WR_TURN;
            load_val  = TURN_LD;
          end else begin
            phase_nxt = PH_RD_ACCESS;
            load_val  = RD_LD;
          end
        end
      end
      PH_WR_TURN: begin
        if (expire) begin
          phase_nxt = PH_WR_DRIVE;
          load      = 1'b1;
          load_val  = DRIVE_LD;
        end
      end
      PH_WR_DRIVE: begin
        if (expire) begin
          phase_nxt = PH_WR_HOLD;
          load      = 1'b1;
          load_val  = '0;
        end
      end
      PH_WR_HOLD: begin
        phase_nxt = PH_IDLE;
      end
      PH_RD_ACCESS: begin
        if (expire) begin
          phase_nxt = PH_IDLE;
          capture   = 1'b1;
        end
      end
      default: phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_nxt;
  end

  assign phase = phase_q;
endmodule

// File: rtl/sram_pin_driver.sv
`timescale 1ns/1ps
module sram_pin_driver
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            phase_nxt,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs1_n,
  output logic              sram_cs2,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe
);
  strobe_t           pins_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  // strobes are registered from the next phase so pins follow the phase glitch-free
  always_ff @(posedge clk) begin
    if (!rst_n) pins_q <= phase_strobes(PH_IDLE);
    else        pins_q <= phase_strobes(phase_nxt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assign sram_addr   = addr_q;
  assign sram_dq_out = wdata_q;
  assign sram_cs1_n  = pins_q.cs1_n;
  assign sram_cs2    = pins_q.cs2;
  assign sram_we_n   = pins_q.we_n;
  assign sram_oe_n   = pins_q.oe_n;
  assign sram_dq_oe  = pins_q.dq_oe;
endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_rdata <= dq_in;
    end
  end
endmodule

// File: rtl/sram_strobe_ctrl.sv
`timescale 1ns/1ps
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W           = 17,
  parameter int unsigned DATA_W           = 8,
  parameter int unsigned CLK_PERIOD_NS    = 10,
  parameter int unsigned T_WR_CYCLE_NS    = 25,
  parameter int unsigned T_WR_PULSE_NS    = 20,
  parameter int unsigned T_DATA_SETUP_NS  = 15,
  parameter int unsigned T_WE_TO_HIZ_NS   = 8,
  parameter int unsigned T_OE_TO_HIZ_NS   = 8,
  parameter int unsigned T_RD_CYCLE_NS    = 25,
  parameter int unsigned T_ADDR_ACCESS_NS = 25,
  parameter int unsigned T_OE_ACCESS_NS   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs1_n,
  output logic              sram_cs2,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);
  localparam int unsigned TURN_CYC  = wr_turn_cycles(CLK_PERIOD_NS, T_WE_TO_HIZ_NS, T_OE_TO_HIZ_NS);
  localparam int unsigned DRIVE_CYC = wr_drive_cycles(CLK_PERIOD_NS, T_DATA_SETUP_NS, T_WR_PULSE_NS,
                                                      T_WR_CYCLE_NS, TURN_CYC);
  localparam int unsigned RD_CYC    = rd_access_cycles(CLK_PERIOD_NS, T_ADDR_ACCESS_NS,
                                                       T_OE_ACCESS_NS, T_RD_CYCLE_NS);
  localparam int unsigned MAX_LEN   = umax(TURN_CYC, umax(DRIVE_CYC, RD_CYC));
  localparam int unsigned CNT_W     = (MAX_LEN < 2) ? 1 : $clog2(MAX_LEN);

  // named internal events
  logic             accept_evt;
  logic             phase_expire;
  logic             timer_load;
  logic [CNT_W-1:0] timer_load_val;
  logic             capture_evt;
  phase_t           phase_cur;
  phase_t           phase_nxt;

  assign req_ready  = (phase_cur == PH_IDLE);
  assign accept_evt = req_valid && req_ready;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (timer_load_val),
    .expire   (phase_expire)
  );

  sram_seq_fsm #(
    .TURN_CYC  (TURN_CYC),
    .DRIVE_CYC (DRIVE_CYC),
    .RD_CYC    (RD_CYC),
    .CNT_W     (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept_evt),
    .is_write  (req_write),
    .expire    (phase_expire),
    .phase     (phase_cur),
    .phase_nxt (phase_nxt),
    .load      (timer_load),
    .load_val  (timer_load_val),
    .capture   (capture_evt)
  );

  sram_pin_driver #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase_nxt   (phase_nxt),
    .accept      (accept_evt),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .sram_addr   (sram_addr),
    .sram_cs1_n  (sram_cs1_n),
    .sram_cs2    (sram_cs2),
    .sram_we_n   (sram_we_n),
    .sram_oe_n   (sram_oe_n),
    .sram_dq_out (sram_dq_out),
    .sram_dq_oe  (sram_dq_oe)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_rcap (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (capture_evt),
    .dq_in     (sram_dq_in),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );
endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_chk #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              accept_evt,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_cs1_n,
  input logic              sram_cs2,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic [DATA_W-1:0] sram_dq_out,
  input logic              sram_dq_oe
);
  assert_idle_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_cs1_n && !sram_cs2 && sram_we_n && sram_oe_n && !sram_dq_oe));

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> !req_ready);

  assert_write_only_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (!sram_cs1_n && sram_cs2 && sram_oe_n));

  assert_turnaround_undriven_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_we_n) |-> !sram_dq_oe);

  assert_hold_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (sram_dq_oe && $stable(sram_addr)));

  assert_driven_data_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_out));

  assert_no_drive_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> (!sram_dq_oe && !sram_cs1_n && sram_cs2));

  assert_rsp_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_rsp_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $rose(sram_oe_n));

  assert_no_strobe_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_we_n && !sram_oe_n));
endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .accept_evt  (accept_evt),
  .rsp_valid   (rsp_valid),
  .sram_addr   (sram_addr),
  .sram_cs1_n  (sram_cs1_n),
  .sram_cs2    (sram_cs2),
  .sram_we_n   (sram_we_n),
  .sram_oe_n   (sram_oe_n),
  .sram_dq_out (sram_dq_out),
  .sram_dq_oe  (sram_dq_oe)
);

// File: tb/sim_sram_strobe_ctrl.sv
`timescale 1ns/1ps
module sim_sram_strobe_ctrl;
  localparam int AW = 17;
  localparam int DW = 8;
  localparam int PER = 10;

  // expected window lengths, derived from the bench's timing choices
  function automatic int up(input int ns);
    int c;
    c = ns / PER;
    if (c * PER < ns) c = c + 1;
    return c;
  endfunction
  localparam int EXP_TURN  = (up(15) > up(8)) ? up(15) : up(8);                 // 2
  localparam int EXP_DRIVE = (up(25) > up(35) - EXP_TURN) ? up(25) : up(35) - EXP_TURN; // 3
  localparam int EXP_RD    = up(45);                                           // 5
  localparam int EXP_WBUSY = EXP_TURN + EXP_DRIVE + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] sram_addr;
  logic sram_cs1_n, sram_cs2, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [DW-1:0] sram_dq_out;
  logic [DW-1:0] sram_dq_in = '0;

  always #5 clk = ~clk;

  sram_strobe_ctrl #(
    .CLK_PERIOD_NS(PER), .T_WE_TO_HIZ_NS(15), .T_DATA_SETUP_NS(25),
    .T_WR_PULSE_NS(35), .T_ADDR_ACCESS_NS(45)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
    .sram_cs1_n(sram_cs1_n), .sram_cs2(sram_cs2), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
    .sram_dq_in(sram_dq_in)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference contents, scoreboard and RAM model
  logic [DW-1:0] ref_mem  [int];
  logic [DW-1:0] sram_arr [int];
  logic [DW-1:0] exp_q [$];
  logic [AW-1:0] cur_addr = '0;
  logic [DW-1:0] cur_wdata = '0;
  bit last_op_write = 0;

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    #1;
    cur_addr = a; cur_wdata = d; last_op_write = wr;
    if (wr) ref_mem[int'(a)] = d;
    else exp_q.push_back(ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  // monitor: protocol checks, RAM model, scoreboard pop
  logic prev_we_n = 1, prev_oe_n = 1, prev_rsp = 0;
  logic [AW-1:0] prev_addr = '0;
  logic [DW-1:0] prev_dq = '0;
  int we_low = 0, rd_cnt = 0, busy = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (req_ready && busy == 0)
        chk(sram_cs1_n && !sram_cs2 && sram_we_n && sram_oe_n && !sram_dq_oe,
            "R1 idle pins", {sram_cs1_n, sram_cs2, sram_we_n, sram_oe_n, sram_dq_oe}, 5'b10110);
      if (!sram_we_n) begin
        we_low++;
        chk(!sram_cs1_n && sram_cs2 && sram_oe_n, "R3 write strobes",
            {sram_cs1_n, sram_cs2, sram_oe_n}, 3'b011);
        chk(sram_addr == cur_addr, "R3 write address", sram_addr, cur_addr);
        if (we_low <= EXP_TURN) chk(!sram_dq_oe, "R4 turnaround undriven", sram_dq_oe, 0);
        else begin
          chk(sram_dq_oe, "R5 data driven", sram_dq_oe, 1);
          chk(sram_dq_out == cur_wdata, "R5 write data", sram_dq_out, cur_wdata);
        end
      end
      if (!prev_we_n && sram_we_n) begin
        chk(we_low == EXP_TURN + EXP_DRIVE, "R3 write strobe width", we_low, EXP_TURN + EXP_DRIVE);
        chk(sram_dq_oe && sram_addr == prev_addr, "R5 hold after strobe", sram_addr, prev_addr);
        sram_arr[int'(prev_addr)] = prev_dq;
        we_low = 0;
      end
      chk(!(!sram_we_n && !sram_oe_n), "R9 strobe overlap", {sram_we_n, sram_oe_n}, 2'b11);
      if (!sram_oe_n) begin
        rd_cnt++;
        chk(sram_we_n && !sram_dq_oe && !sram_cs1_n && sram_cs2, "R6 read strobes",
            {sram_we_n, sram_dq_oe, sram_cs1_n, sram_cs2}, 4'b1001);
      end
      if (!prev_oe_n && sram_oe_n) begin
        chk(rd_cnt == EXP_RD, "R6 read strobe width", rd_cnt, EXP_RD);
        rd_cnt = 0;
      end
      if (!req_ready) busy++;
      else if (busy != 0) begin
        chk(busy == (last_op_write ? EXP_WBUSY : EXP_RD), "R2 busy length", busy,
            last_op_write ? EXP_WBUSY : EXP_RD);
        busy = 0;
      end
      if (rsp_valid) begin
        chk(!prev_oe_n && sram_oe_n && !prev_rsp, "R7 response timing",
            {prev_oe_n, sram_oe_n, prev_rsp}, 3'b010);
        if (exp_q.size() == 0) chk(0, "R7 unexpected response", rsp_rdata, 0);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk(rsp_rdata == e, "R8 read data", rsp_rdata, e);
        end
      end
      // RAM model: data only valid from the second access cycle
      if (!sram_oe_n && sram_we_n && !sram_cs1_n && sram_cs2)
        sram_dq_in = (rd_cnt >= 2) ? (sram_arr.exists(int'(sram_addr)) ? sram_arr[int'(sram_addr)] : 8'h00)
                                   : 8'hEE;
      else sram_dq_in = 8'h00;
      prev_we_n = sram_we_n; prev_oe_n = sram_oe_n; prev_rsp = rsp_valid;
      prev_addr = sram_addr; prev_dq = sram_dq_out;
    end
  end

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sram_cs1_n && !sram_cs2 && sram_we_n && sram_oe_n && !sram_dq_oe && !rsp_valid,
        "R1 reset pins", {sram_cs1_n, sram_cs2, sram_we_n, sram_oe_n, sram_dq_oe, rsp_valid}, 6'b101100);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1 ready after reset", req_ready, 1);
    issue(1, 17'h00000, 8'hA5);
    issue(1, 17'h1FFFF, 8'h3C);
    issue(0, 17'h00000, 8'h00);
    issue(0, 17'h1FFFF, 8'h00);
    issue(1, 17'h00100, 8'h5A);   // write right after a read: turnaround
    issue(0, 17'h00100, 8'h00);   // read right after a write
    issue(1, 17'h00000, 8'hC3);   // overwrite
    issue(0, 17'h00000, 8'h00);
    for (int i = 0; i < 8; i++) issue(1, AW'((i * 4099 + 7) % 131072), DW'(i * 37 + 11));
    for (int i = 7; i >= 0; i--) issue(0, AW'((i * 4099 + 7) % 131072), 8'h00);
    for (int i = 0; i < 4; i++) begin
      issue(1, AW'(i * 3), DW'(8'hF0 ^ i));
      issue(0, AW'(i * 3), 8'h00);
    end
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all reads answered", exp_q.size(), 0);
    finish_run();
  end
endmodule